// File: doc/BRIEF.md
# Single-Channel Basic DMA Transfer Engine

This block is one DMA channel that moves bytes from a source to a destination whenever a peripheral raises a request. Software loads three configuration words: a source end address, a destination end address and a control word. Both addresses point at the last item of a transfer, not the first. The control word holds the cycle type, the remaining transfer count minus one, an arbitration rate and the increment and size codes for each side.

On every transfer the channel derives its addresses from the end addresses. It steps back by the number of items still to move, scaled by the increment step. A fixed destination, such as a peripheral data register, uses the "no increment" code, and every write then goes to the end address itself. Each request moves a burst whose length is set by the arbitration rate. The channel then waits for the next request. After the last item it writes the cycle type back as stopped and pulses a completion output. Reads and writes go out on a simple byte-wide memory master port.

Top module: `dma_basic_chan`

## Requirements
- R1: The configuration port holds three words, selected by cfg_addr_i: 0 is the source end address, 1 is the destination end address and 2 is the control word. Address 3 reads as zero. cfg_rdata_o returns the selected word in the same cycle. The control word fields are: cycle type in bits [2:0] (1 = basic, 0 = stopped), count minus one in [13:4], arbitration code R in [17:14], source size in [25:24] (0 = byte), source increment in [27:26], destination size in [29:28] (0 = byte) and destination increment in [31:30].
- R2: With k items remaining, the address on each side is its end address minus (k-1) times the step. Increment code 0 gives a step of 1 byte, code 1 gives 2 bytes and code 2 gives 4 bytes. Code 3 gives no increment, so the address is always the end address.
- R3: Each transfer uses one clock cycle with mem_rd_o high at the source address. It is followed in the next cycle by mem_wr_o high at the destination address. In that write cycle mem_wdata_o carries mem_rdata_i, which the memory returns in the cycle after the read strobe.
- R4: A request moves min(2^R, k) items back to back, where k is the number of items remaining. R = 0 moves exactly one item per request, and the channel then waits for the next request.
- R5: After each transfer that is not the last, the count field decrements by one.
- R6: After the last transfer, the cycle type becomes 0 (stopped) and the count field reads 0. done_o is high for exactly one cycle: the cycle after the final write.
- R7: A request is ignored when chan_en_i is low, when the cycle type is not 1, or while a burst is in progress.
- R8: Configuration writes that arrive while a burst is in progress have no effect.
- R9: After reset all configuration words read as zero, and mem_rd_o, mem_wr_o and done_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chan_en_i | input | 1 | Channel enable |
| req_i | input | 1 | Peripheral transfer request |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | Configuration word select |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Configuration read data |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_addr_o | output | AW | Memory address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, valid the cycle after the read strobe |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench checks that the first transfer reads the lowest address, end minus (count-1) times the step. A design that counted forward from the end address would show up as wrong data order or addresses above the end. Fixed-destination runs check that every write lands on the end address; a design that applied the step on that side anyway would spread the writes. Burst runs with a rate larger than the remaining count check that the burst stops at the last item. They also check that done pulses only once. The bench sends requests after the stop, with the channel disabled, and during a burst, and sends configuration writes while busy. A design that latched any of these would produce extra writes or corrupt the readback.

// File: rtl/dma_basic_pkg.sv
package dma_basic_pkg;
  localparam int CNT_W = 10;

  localparam logic [2:0] CYC_STOP  = 3'd0;
  localparam logic [2:0] CYC_BASIC = 3'd1;
  localparam logic [1:0] INC_NONE  = 2'd3;

  localparam logic [1:0] CFG_SRC  = 2'd0;
  localparam logic [1:0] CFG_DST  = 2'd1;
  localparam logic [1:0] CFG_CTRL = 2'd2;

  typedef struct packed {
    logic [1:0]       dst_inc;
    logic [1:0]       dst_size;
    logic [1:0]       src_inc;
    logic [1:0]       src_size;
    logic [5:0]       rsvd_hi;
    logic [3:0]       arb;
    logic [CNT_W-1:0] cnt_m1;
    logic             rsvd_lo;
    logic [2:0]       cycle;
  } ctrl_t;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} st_e;
endpackage

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
  import dma_basic_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0]    end_i,
  input  logic [CNT_W-1:0] cnt_m1_i,
  input  logic [1:0]       inc_i,
  output logic [AW-1:0]    addr_o
);
  logic [AW-1:0] offs;

  always_comb begin
    offs = AW'(cnt_m1_i) << inc_i;
    addr_o = (inc_i == INC_NONE) ? end_i : end_i - offs;
  end
endmodule

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
  import dma_basic_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [1:0]    addr_i,
  input  logic [31:0]   wdata_i,
  input  logic          busy_i,
  input  logic          xfer_i,
  output logic [AW-1:0] src_end_o,
  output logic [AW-1:0] dst_end_o,
  output ctrl_t         ctrl_o,
  output logic [31:0]   rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_end_o <= '0;
      dst_end_o <= '0;
      ctrl_o    <= '0;
    end else if (xfer_i) begin
      if (ctrl_o.cnt_m1 == '0) ctrl_o.cycle  <= CYC_STOP;
      else                     ctrl_o.cnt_m1 <= ctrl_o.cnt_m1 - 1'b1;
    end else if (we_i && !busy_i) begin
      case (addr_i)
        CFG_SRC:  src_end_o <= AW'(wdata_i);
        CFG_DST:  dst_end_o <= AW'(wdata_i);
        CFG_CTRL: ctrl_o    <= ctrl_t'(wdata_i);
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (addr_i)
      CFG_SRC:  rdata_o = 32'(src_end_o);
      CFG_DST:  rdata_o = 32'(dst_end_o);
      CFG_CTRL: rdata_o = 32'(ctrl_o);
      default:  rdata_o = '0;
    endcase
  end

  // R5: non-final transfer decrements count
  p_count_dec_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_i && ctrl_o.cnt_m1 != '0) |=> ctrl_o.cnt_m1 == $past(ctrl_o.cnt_m1) - 1'b1);
  // R8: end addresses hold while busy
  p_cfg_block_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> ($stable(src_end_o) && $stable(dst_end_o)));
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_basic_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             req_i,
  input  logic [2:0]       cycle_i,
  input  logic [CNT_W-1:0] cnt_m1_i,
  input  logic [3:0]       arb_i,
  output logic             busy_o,
  output logic             rd_o,
  output logic             xfer_o,
  output logic             done_o
);
  localparam int BW = CNT_W + 1;

  st_e           state;
  logic [BW-1:0] burst_left;
  logic [15:0]   pow_len, rem_len;
  logic [BW-1:0] blen;
  logic          last;

  always_comb begin
    pow_len = 16'd1 << arb_i;
    rem_len = 16'(cnt_m1_i) + 16'd1;
    blen    = (pow_len < rem_len) ? BW'(pow_len) : BW'(rem_len);
    last    = (cnt_m1_i == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state      <= ST_IDLE;
      burst_left <= '0;
      done_o     <= 1'b0;
    end else begin
      done_o <= (state == ST_WR) && last;
      case (state)
        ST_IDLE: if (en_i && req_i && cycle_i == CYC_BASIC) begin
          state      <= ST_RD;
          burst_left <= blen;
        end
        ST_RD: state <= ST_WR;
        ST_WR: begin
          if (last || burst_left == BW'(1)) state <= ST_IDLE;
          else begin
            state      <= ST_RD;
            burst_left <= burst_left - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state != ST_IDLE);
  assign rd_o   = (state == ST_RD);
  assign xfer_o = (state == ST_WR);

  // R7: no start without enable and basic cycle
  p_ignore_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE && !(en_i && cycle_i == CYC_BASIC)) |=> !rd_o);
  // R4: burst never runs with an empty budget
  p_burst_cap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |-> burst_left != '0);
endmodule

// File: rtl/dma_basic_chan.sv
module dma_basic_chan
  import dma_basic_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          chan_en_i,
  input  logic          req_i,
  input  logic          cfg_we_i,
  input  logic [1:0]    cfg_addr_i,
  input  logic [31:0]   cfg_wdata_i,
  output logic [31:0]   cfg_rdata_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [7:0]    mem_wdata_o,
  input  logic [7:0]    mem_rdata_i,
  output logic          done_o
);
  logic [AW-1:0] src_end, dst_end, src_addr, dst_addr;
  ctrl_t         ctrl;
  logic          busy, rd, xfer;

  dma_cfg_regs #(.AW(AW)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i),
    .addr_i    (cfg_addr_i),
    .wdata_i   (cfg_wdata_i),
    .busy_i    (busy),
    .xfer_i    (xfer),
    .src_end_o (src_end),
    .dst_end_o (dst_end),
    .ctrl_o    (ctrl),
    .rdata_o   (cfg_rdata_o)
  );

  dma_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (chan_en_i),
    .req_i    (req_i),
    .cycle_i  (ctrl.cycle),
    .cnt_m1_i (ctrl.cnt_m1),
    .arb_i    (ctrl.arb),
    .busy_o   (busy),
    .rd_o     (rd),
    .xfer_o   (xfer),
    .done_o   (done_o)
  );

  dma_addr_gen #(.AW(AW)) u_src_addr (
    .end_i    (src_end),
    .cnt_m1_i (ctrl.cnt_m1),
    .inc_i    (ctrl.src_inc),
    .addr_o   (src_addr)
  );

  dma_addr_gen #(.AW(AW)) u_dst_addr (
    .end_i    (dst_end),
    .cnt_m1_i (ctrl.cnt_m1),
    .inc_i    (ctrl.dst_inc),
    .addr_o   (dst_addr)
  );

  assign mem_rd_o    = rd;
  assign mem_wr_o    = xfer;
  assign mem_addr_o  = rd ? src_addr : dst_addr;
  assign mem_wdata_o = xfer ? mem_rdata_i : 8'h00;

  // R6: completion implies stopped cycle, single pulse
  p_done_stop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ctrl.cycle == CYC_STOP);
  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R3: write follows read
  p_wr_follow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> $past(mem_rd_o));
  p_rd_then_wr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> mem_wr_o);
  // R2: fixed destination stays on end address
  p_fixed_dst_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_o && ctrl.dst_inc == INC_NONE) |-> mem_addr_o == dst_end);
endmodule

// File: tb/dma_basic_chan_tb.sv
module dma_basic_chan_tb_top;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0, req = 1'b0, cfg_we = 1'b0;
  logic [1:0]    cfg_addr = '0;
  logic [31:0]   cfg_wdata = '0, cfg_rdata;
  logic          mem_rd, mem_wr, done;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata, mem_rdata = '0;

  logic [7:0]  mem [256];
  logic [31:0] wr_addr [64];
  logic [7:0]  wr_data [64];
  int          wr_cnt = 0, done_cnt = 0;
  int          checks = 0, fails = 0;
  bit          finished = 0;

  always #10 clk = ~clk;

  dma_basic_chan #(.AW(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .chan_en_i(en), .req_i(req),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(cfg_rdata), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .done_o(done)
  );

  initial for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'hA5;

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
    if (mem_wr) begin
      mem[mem_addr[7:0]] <= mem_wdata;
      if (wr_cnt < 64) begin
        wr_addr[wr_cnt] = mem_addr;
        wr_data[wr_cnt] = mem_wdata;
      end
      wr_cnt++;
    end
    if (done) done_cnt++;
  end

  function automatic logic [7:0] src_byte(int a);
    return 8'(a) ^ 8'hA5;
  endfunction

  function automatic logic [31:0] mk_ctrl(logic [1:0] dinc, logic [1:0] sinc,
                                          logic [3:0] arb, logic [9:0] nm1, logic [2:0] cyc);
    return {dinc, 2'b00, sinc, 2'b00, 6'b0, arb, nm1, 1'b0, cyc};
  endfunction

  task automatic check(bit ok, string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
    end
  endtask

  task automatic cfg_write(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic pulse_req(int settle);
    @(negedge clk);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    repeat (settle) @(negedge clk);
  endtask

  task automatic setup(logic [31:0] s, logic [31:0] d, logic [31:0] c);
    cfg_write(2'd0, s);
    cfg_write(2'd1, d);
    cfg_write(2'd2, c);
    wr_cnt = 0;
    done_cnt = 0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check(!mem_rd && !mem_wr && !done, "R9", {29'b0, mem_rd, mem_wr, done}, 0);
    for (int a = 0; a < 4; a++) begin
      cfg_read(2'(a), v);
      check(v == 0, "R9", v, 0);
    end
  endtask

  task automatic t_to_fixed_dst;
    logic [31:0] v;
    en = 1'b1;
    setup(32'h13, 32'h80, mk_ctrl(2'd3, 2'd0, 4'd0, 10'd3, 3'd1));
    cfg_read(2'd2, v);
    check(v == mk_ctrl(2'd3, 2'd0, 4'd0, 10'd3, 3'd1), "R1", v, mk_ctrl(2'd3, 2'd0, 4'd0, 10'd3, 3'd1));
    pulse_req(4);
    check(wr_cnt == 1, "R4", wr_cnt, 1);
    cfg_read(2'd2, v);
    check(v[13:4] == 10'd2, "R5", v[13:4], 2);
    for (int i = 0; i < 3; i++) pulse_req(4);
    check(wr_cnt == 4, "R4", wr_cnt, 4);
    for (int i = 0; i < 4; i++) begin
      check(wr_addr[i] == 32'h80, "R2", wr_addr[i], 32'h80);
      check(wr_data[i] == src_byte(16 + i), "R3", wr_data[i], src_byte(16 + i));
    end
    check(done_cnt == 1, "R6", done_cnt, 1);
    cfg_read(2'd2, v);
    check(v[2:0] == 3'd0 && v[13:4] == 10'd0, "R6", v, {v[31:14], 10'd0, v[3], 3'd0});
  endtask

  task automatic t_ignored;
    logic [31:0] v;
    pulse_req(6);
    check(wr_cnt == 4, "R7 stopped", wr_cnt, 4);
    setup(32'h13, 32'h84, mk_ctrl(2'd3, 2'd0, 4'd0, 10'd1, 3'd1));
    en = 1'b0;
    pulse_req(6);
    check(wr_cnt == 0, "R7 disabled", wr_cnt, 0);
    cfg_read(2'd2, v);
    check(v[13:4] == 10'd1 && v[2:0] == 3'd1, "R7", v, mk_ctrl(2'd3, 2'd0, 4'd0, 10'd1, 3'd1));
    en = 1'b1;
  endtask

  task automatic t_burst_copy;
    logic [31:0] v;
    setup(32'h27, 32'h47, mk_ctrl(2'd0, 2'd0, 4'd2, 10'd5, 3'd1));
    pulse_req(12);
    check(wr_cnt == 4, "R4 burst", wr_cnt, 4);
    cfg_read(2'd2, v);
    check(v[13:4] == 10'd1, "R5", v[13:4], 1);
    check(done_cnt == 0, "R6 early", done_cnt, 0);
    pulse_req(12);
    check(wr_cnt == 6, "R4 cap", wr_cnt, 6);
    for (int i = 0; i < 6; i++) begin
      check(wr_addr[i] == 32'h42 + i, "R2", wr_addr[i], 32'h42 + i);
      check(wr_data[i] == src_byte(32'h22 + i), "R3", wr_data[i], src_byte(32'h22 + i));
    end
    check(done_cnt == 1, "R6", done_cnt, 1);
  endtask

  task automatic t_wide_steps;
    setup(32'h34, 32'h68, mk_ctrl(2'd2, 2'd1, 4'd3, 10'd2, 3'd1));
    pulse_req(10);
    check(wr_cnt == 3, "R4", wr_cnt, 3);
    for (int i = 0; i < 3; i++) begin
      check(wr_addr[i] == 32'h60 + 4 * i, "R2 step4", wr_addr[i], 32'h60 + 4 * i);
      check(wr_data[i] == src_byte(32'h30 + 2 * i), "R2 step2", wr_data[i], src_byte(32'h30 + 2 * i));
    end
    check(done_cnt == 1, "R6", done_cnt, 1);
  endtask

  task automatic t_busy_writes;
    logic [31:0] v;
    setup(32'h13, 32'h90, mk_ctrl(2'd3, 2'd0, 4'd1, 10'd2, 3'd1));
    @(negedge clk);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = 32'hFF;
    @(negedge clk);
    req = 1'b1;
    cfg_addr = 2'd2; cfg_wdata = mk_ctrl(2'd3, 2'd0, 4'd0, 10'd9, 3'd1);
    @(negedge clk);
    cfg_we = 1'b0;
    req = 1'b0;
    repeat (6) @(negedge clk);
    check(wr_cnt == 2, "R7 busy", wr_cnt, 2);
    cfg_read(2'd0, v);
    check(v == 32'h13, "R8", v, 32'h13);
    cfg_read(2'd2, v);
    check(v[13:4] == 10'd0, "R8", v[13:4], 0);
    check(wr_data[0] == src_byte(32'h11) && wr_data[1] == src_byte(32'h12), "R2",
          {wr_data[0], wr_data[1]}, {src_byte(32'h11), src_byte(32'h12)});
    pulse_req(4);
    check(wr_cnt == 3 && wr_data[2] == src_byte(32'h13), "R4", wr_data[2], src_byte(32'h13));
    check(done_cnt == 1, "R6", done_cnt, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_to_fixed_dst();
    t_ignored();
    t_burst_copy();
    t_wide_steps();
    t_busy_writes();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule